// File: doc/BRIEF.md
# Two-Channel Sampling Converter Readout Interface

This block is the digital side of a two-channel 8-bit sampling converter. A host starts a sample by pulling the convert-start line low. It chooses the channel by the number of low-going toggles it makes on that line. One falling edge selects channel 0. A second high-then-low toggle, made inside a short window after the first edge, selects channel 1. The converted codes for both channels arrive on parallel input ports. Both are captured at the first accepted edge, so the value that comes out is the one present when the sample began.

After the start edge, an internal timer counts the conversion interval on the system clock. The serial clock plays no part in that timing. For the whole interval the data output is enabled and held low. When the interval ends, the most significant bit of the result appears at once. The host then shifts the rest of the word out with its own serial clock, which may idle high or low. Eight rising edges of the serial clock finish the word. A fixed delay after the eighth rising edge, the output enable drops, which models the pin going high impedance.

The convert-start line and the serial clock are both asynchronous to the system clock. Each one passes through a two-flop synchroniser before edges are detected. All timing limits are parameters counted in system clock cycles.

Top module: `dual_chan_serial_adc_if`

## Requirements
- R1: After reset the output enable `sdo_en` is 0 and no conversion is in progress.
- R2: A falling edge of `cnv_n` starts a conversion only if `cnv_n` had been high for at least HIGH_MIN_CYC system clock cycles. A shorter high pulse is ignored, whether the line idles high or low.
- R3: A second qualified falling edge within WIN_CYC cycles of the first selects channel 1. If none arrives, channel 0 is used. Falling edges that arrive after the window and before the conversion ends are ignored.
- R4: Both `ch0_val` and `ch1_val` are captured at the first accepted falling edge. Changes made to them later do not alter the result.
- R5: From the start edge until CONV_CYC cycles have passed, `sdo_en` is 1 and `sdo` is 0.
- R6: Once the conversion ends, `sdo` presents bit 7 of the selected channel's code, which is straight unsigned binary.
- R7: A falling edge of `sclk` moves `sdo` to the next lower bit only if a rising edge of `sclk` has come since the last move. The word therefore leaves MSB first with `sclk` idling either low or high.
- R8: HIZ_CYC cycles after the 8th rising edge of `sclk`, `sdo_en` returns to 0. Further `sclk` edges do not enable the output again.
- R9: A qualified falling edge of `cnv_n` during readout, or during the wait before the output is released, abandons the current word and starts a new conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the conversion timer runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_n | input | 1 | Convert-start line; asynchronous, acts on its falling edges |
| sclk | input | 1 | Host serial clock; asynchronous, either idle level |
| ch0_val | input | DW | Converted code for channel 0 |
| ch1_val | input | DW | Converted code for channel 1 |
| sdo | output | 1 | Serial data: low while busy, then result bits MSB first |
| sdo_en | output | 1 | Output drive enable; 0 means the pin is high impedance |

## Verification
A wrong channel flag or a wrong capture shows up as a wrong byte in the scoreboard at the end of that readout. A bit-index error shows up on the very next bit the host samples. A conversion counter that runs short or long makes `sdo` leave the low busy level on the wrong side of the interval boundary, and the bench samples a few cycles before and after that boundary to catch it. A state that fails to leave readout keeps `sdo_en` high after the release delay, and the bench sees that within a few tens of cycles of the 8th rising edge.

// File: rtl/dual_chan_serial_adc_if.sv
module dual_chan_serial_adc_if #(
  parameter int DW           = 8,
  parameter int CONV_CYC     = 1500,
  parameter int WIN_CYC      = 200,
  parameter int HIGH_MIN_CYC = 10,
  parameter int HIZ_CYC      = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnv_n,
  input  logic          sclk,
  input  logic [DW-1:0] ch0_val,
  input  logic [DW-1:0] ch1_val,
  output logic          sdo,
  output logic          sdo_en
);

  localparam int CW = $clog2(CONV_CYC + 1);
  localparam int WW = $clog2(WIN_CYC + 1);
  localparam int HW = $clog2(HIGH_MIN_CYC + 1);
  localparam int ZW = $clog2(HIZ_CYC + 1);
  localparam int BW = $clog2(DW + 1);

  typedef enum logic [2:0] {S_IDLE, S_WIN, S_CONV, S_READ, S_HZW} st_t;

  st_t           st;
  logic [2:0]    cs, ks;
  logic [HW-1:0] hi_cnt;
  logic [CW-1:0] conv_cnt;
  logic [WW-1:0] win_cnt;
  logic [ZW-1:0] hz_cnt;
  logic [BW-1:0] rises, idx;
  logic [DW-1:0] cap0, cap1, word, shifted;
  logic          sel1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs <= '1;
      ks <= '0;
    end else begin
      cs <= {cs[1:0], cnv_n};
      ks <= {ks[1:0], sclk};
    end

  wire cnv_fall  = cs[2] & ~cs[1];
  wire sk_rise   = ks[1] & ~ks[2];
  wire sk_fall   = ~ks[1] & ks[2];
  wire qual_fall = cnv_fall && (hi_cnt >= HW'(HIGH_MIN_CYC));
  wire start     = qual_fall && (st == S_IDLE || st == S_READ || st == S_HZW);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        hi_cnt <= '0;
    else if (!cs[1])                   hi_cnt <= '0;
    else if (hi_cnt < HW'(HIGH_MIN_CYC)) hi_cnt <= hi_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      conv_cnt <= '0;
      win_cnt  <= '0;
      hz_cnt   <= '0;
      rises    <= '0;
      idx      <= '0;
      cap0     <= '0;
      cap1     <= '0;
      sel1     <= 1'b0;
    end else if (start) begin
      st       <= S_WIN;
      conv_cnt <= '0;
      win_cnt  <= '0;
      hz_cnt   <= '0;
      rises    <= '0;
      idx      <= '0;
      cap0     <= ch0_val;
      cap1     <= ch1_val;
      sel1     <= 1'b0;
    end else begin
      case (st)
        S_WIN: begin
          conv_cnt <= conv_cnt + 1'b1;
          if (qual_fall) begin
            sel1 <= 1'b1;
            st   <= S_CONV;
          end else if (win_cnt == WW'(WIN_CYC - 1)) st <= S_CONV;
          else win_cnt <= win_cnt + 1'b1;
        end
        S_CONV:
          if (conv_cnt == CW'(CONV_CYC - 1)) st <= S_READ;
          else conv_cnt <= conv_cnt + 1'b1;
        S_READ: begin
          if (sk_rise) begin
            rises <= rises + 1'b1;
            if (rises == BW'(DW - 1)) begin
              st     <= S_HZW;
              hz_cnt <= '0;
            end
          end
          if (sk_fall && rises > idx && idx < BW'(DW - 1))
            idx <= idx + 1'b1;
        end
        S_HZW:
          if (hz_cnt == ZW'(HIZ_CYC - 1)) st <= S_IDLE;
          else hz_cnt <= hz_cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end

  assign word    = sel1 ? cap1 : cap0;
  assign shifted = word << idx;
  assign sdo_en  = (st != S_IDLE);
  assign sdo     = (st == S_READ || st == S_HZW) ? shifted[DW-1] : 1'b0;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (sdo_en && !sdo)); // R5

  AST_CH1_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel1) |-> ($past(st) == S_WIN)); // R3

  AST_LATE_EDGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV && qual_fall) |=> $stable(sel1)); // R3

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && !sk_fall && !start) |=> $stable(sdo)); // R7

  AST_HIZ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HZW && hz_cnt == ZW'(HIZ_CYC - 1) && !start) |=> !sdo_en); // R8

endmodule

// File: tb/tb_dual_chan_serial_adc_if.sv
`timescale 1ns/1ps
module tb_dual_chan_serial_adc_if;
  localparam int DW = 8, CONV = 1500, WIN = 200, HMIN = 10, HIZ = 40;

  logic clk = 0, rst_n = 0, cnv_n = 0, sclk = 0;
  logic [DW-1:0] ch0_val = '0, ch1_val = '0;
  logic sdo, sdo_en;
  int total = 0, bad = 0;

  logic [7:0] exp_q[$];
  string      req_q[$];
  logic [7:0] rx_byte;
  event       rx_ev;

  always #2.5 clk = ~clk;

  dual_chan_serial_adc_if #(.DW(DW), .CONV_CYC(CONV), .WIN_CYC(WIN),
    .HIGH_MIN_CYC(HMIN), .HIZ_CYC(HIZ)) dut (
    .clk(clk), .rst_n(rst_n), .cnv_n(cnv_n), .sclk(sclk),
    .ch0_val(ch0_val), .ch1_val(ch1_val), .sdo(sdo), .sdo_en(sdo_en));

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // mode 0: one edge, 1: second edge in window, 2: short glitch in window, 3: second edge late
  task automatic do_conv(int mode, logic [7:0] v0, logic [7:0] v1, bit push, string req);
    logic [7:0] e;
    int k;
    cnv_n = 1; step(30);
    ch0_val = v0; ch1_val = v1;
    cnv_n = 0; k = 0;
    step(10); k = 10;
    ch0_val = ~v0; ch1_val = ~v1;
    case (mode)
      1: begin step(10); cnv_n = 1; step(20); cnv_n = 0; k = 40; end
      2: begin step(10); cnv_n = 1; step(4);  cnv_n = 0; k = 24; end
      3: begin step(290); cnv_n = 1; step(100); cnv_n = 0; k = 400; end
      default: ;
    endcase
    e = (mode == 1) ? v1 : v0;
    if (push) begin exp_q.push_back(e); req_q.push_back(req); end
    step(CONV - 5 - k);
    chk(sdo_en === 1'b1 && sdo === 1'b0, "R5", "busy level before end", {sdo_en, sdo}, 2'b10);
    step(15);
    chk(sdo_en === 1'b1 && sdo === e[7], "R6", "MSB at completion", sdo, e[7]);
  endtask

  task automatic read_byte(bit cpol, int nbits);
    logic [7:0] b = '0;
    for (int i = 0; i < nbits; i++) begin
      if (cpol) begin
        sclk = 0; step(20);
        b = {b[6:0], sdo};
        sclk = 1;
      end else begin
        b = {b[6:0], sdo};
        sclk = 1;
      end
      if (i == 7) begin
        step(10);
        chk(sdo_en === 1'b1, "R8", "enable held just after 8th rise", sdo_en, 1);
        step(60);
        chk(sdo_en === 1'b0, "R8", "released after delay", sdo_en, 0);
        sclk = ~sclk; step(20); sclk = ~sclk; step(20);
        sclk = ~sclk; step(20); sclk = ~sclk; step(20);
        chk(sdo_en === 1'b0, "R8", "extra sclk edges ignored", sdo_en, 0);
        sclk = cpol;
      end else begin
        step(20);
        if (!cpol) begin sclk = 0; step(20); end
      end
    end
    if (nbits == 8) begin
      rx_byte = b;
      -> rx_ev;
    end
  endtask

  initial forever begin
    logic [7:0] e;
    string r;
    @(rx_ev);
    if (exp_q.size() == 0) chk(0, "R6", "unexpected word", rx_byte, 0);
    else begin
      e = exp_q.pop_front(); r = req_q.pop_front();
      chk(rx_byte === e, r, "word read out", rx_byte, e);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R6 watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(5);
    chk(sdo_en === 1'b0, "R1", "enable during reset", sdo_en, 0);
    rst_n = 1; step(20);
    chk(sdo_en === 1'b0, "R1", "enable after reset", sdo_en, 0);

    cnv_n = 1; step(4); cnv_n = 0; step(100);
    chk(sdo_en === 1'b0, "R2", "short high pulse from low idle", sdo_en, 0);

    do_conv(0, 8'hA5, 8'h3C, 1, "R4"); read_byte(0, 8);
    do_conv(1, 8'h12, 8'hC7, 1, "R3"); read_byte(0, 8);
    do_conv(2, 8'h80, 8'h01, 1, "R2"); read_byte(0, 8);
    do_conv(3, 8'h5A, 8'hFF, 1, "R3"); read_byte(0, 8);
    sclk = 1; step(20);
    do_conv(0, 8'hFF, 8'h00, 1, "R7"); read_byte(1, 8);
    do_conv(1, 8'h00, 8'h01, 1, "R7"); read_byte(1, 8);
    sclk = 0; step(20);
    do_conv(0, 8'h33, 8'h66, 0, "R9"); read_byte(0, 3);
    do_conv(1, 8'h44, 8'h96, 1, "R9"); read_byte(0, 8);
    do_conv(0, 8'h01, 8'h7E, 1, "R6"); read_byte(0, 8);

    step(10);
    chk(exp_q.size() == 0, "R6", "all expected words read", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule